// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block picks which interrupt a small 8-bit CPU should service next. Thirteen peripheral sources each carry a 2-bit service level that software programs through a register-write port. There is also a maskable top-level event and a non-maskable software trap. At every instruction boundary, the block compares the pending requests against the CPU's current level. It then raises a take request together with the winner's vector address and the level the CPU must load.

When the CPU acknowledges a take, the block saves the level that was interrupted on an internal four-entry stack. When the CPU executes a return, the block presents the saved level for the CPU to restore, and pops it. A return with nothing saved, or an acknowledge with the stack already full, leaves the stack untouched and sets a sticky error flag.

Top module: `nest_irq_ctrl`

## Requirements
- R1: `take` is asserted only while `insn_end` is high; with `insn_end` low, `take` stays 0 whatever the requests.
- R2: A pending programmable source is eligible only when its programmed level is strictly greater than `cur_lvl`. Level 3 is the highest level and 0 the lowest.
- R3: Among eligible programmable sources, the highest programmed level wins; on equal levels, the higher source index wins.
- R4: `vec_addr` is FFE0h + 2*index. Programmable sources use indices 0 to 12, the top-level event uses index 13 (FFFAh), and the trap uses index 14 (FFFCh). FFFEh stays reserved for reset.
- R5: `new_lvl` equals the winner's programmed level for a programmable source, and 3 for the top-level event or the trap.
- R6: The top-level event is taken when `cur_lvl` is below 3 and beats every programmable source. At level 3 it is masked.
- R7: The trap is taken at any `cur_lvl`, including 3, and beats every other source.
- R8: After reset, every source level is 3. A write with `wr_en` high and `wr_idx` below 13 stores `wr_lvl` for that source, but a `wr_lvl` of 0 is ignored and the field keeps its old value.
- R9: `ack` pushes `cur_lvl`. A later `iret` with a non-empty stack gives `ret_valid`=1 and `ret_lvl` equal to the most recently pushed level, then pops it (last in, first out).
- R10: `iret` with an empty stack gives `ret_valid`=0 and `ret_lvl`=`cur_lvl`, and sets `stk_err`. `stk_err` stays set until reset.
- R11: `ack` while four levels are already held discards the push and sets `stk_err`; the saved entries are unchanged.
- R12: When `ack` and `iret` are high in the same cycle, the push happens, the `iret` is ignored, and `ret_valid` is 0.
- R13: After reset, the stack is empty, `stk_err` is 0, and `take` is 0 while nothing is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 13 | Pending request per programmable source |
| top_req | input | 1 | Maskable top-level event request |
| trap_req | input | 1 | Software trap request |
| wr_en | input | 1 | Level-field write strobe |
| wr_idx | input | 4 | Source whose level is written |
| wr_lvl | input | 2 | Level value to write |
| cur_lvl | input | 2 | CPU current level |
| insn_end | input | 1 | Current instruction completes this cycle |
| ack | input | 1 | CPU accepts the take; save current level |
| iret | input | 1 | CPU returns from interrupt |
| take | output | 1 | Interrupt must be taken now |
| vec_addr | output | 16 | Vector address of the winner |
| new_lvl | output | 2 | Level to load on entry |
| ret_valid | output | 1 | A saved level is being returned |
| ret_lvl | output | 2 | Level to restore on return |
| stk_err | output | 1 | Sticky stack misuse flag |

## Verification
The hardest situation to reach from the ports is a full stack that receives one more acknowledge, followed by proof that the saved entries survived. The bench gets there in three steps. It drives four acknowledges at four distinct current levels. It then sends a fifth acknowledge carrying a level that differs from the top entry. Finally, it unwinds with returns and checks every restored level in last-in, first-out order. The empty-stack return and the programmed-zero write are reached the same way: in each case the bench follows up with a take or return whose outcome would differ if the ignored action had taken effect.

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl #(
  parameter int NSRC = 13,
  parameter int DEPTH = 4,
  parameter logic [15:0] BASE = 16'hFFE0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            top_req,
  input  logic            trap_req,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [1:0]      wr_lvl,
  input  logic [1:0]      cur_lvl,
  input  logic            insn_end,
  input  logic            ack,
  input  logic            iret,
  output logic            take,
  output logic [15:0]     vec_addr,
  output logic [1:0]      new_lvl,
  output logic            ret_valid,
  output logic [1:0]      ret_lvl,
  output logic            stk_err
);
  localparam int IW = $clog2(NSRC + 3);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [IW-1:0] TOP_IDX  = IW'(NSRC);
  localparam logic [IW-1:0] TRAP_IDX = IW'(NSRC + 1);

  logic [1:0]    prio [NSRC];
  logic [1:0]    stk  [DEPTH];
  logic [DW-1:0] depth;
  logic          hit;
  logic [IW-1:0] win_idx;
  logic [1:0]    win_lvl;

  wire full  = (depth == DW'(DEPTH));
  wire empty = (depth == '0);
  wire [AW-1:0] top_ptr = AW'(depth - 1'b1);

  always_comb begin
    hit = 1'b0;
    win_idx = '0;
    win_lvl = 2'd0;
    for (int i = 0; i < NSRC; i++) begin
      if (irq_req[i] && prio[i] > cur_lvl && (!hit || prio[i] >= win_lvl)) begin
        hit = 1'b1;
        win_idx = IW'(i);
        win_lvl = prio[i];
      end
    end
    if (top_req && cur_lvl != 2'd3) begin
      hit = 1'b1;
      win_idx = TOP_IDX;
      win_lvl = 2'd3;
    end
    if (trap_req) begin
      hit = 1'b1;
      win_idx = TRAP_IDX;
      win_lvl = 2'd3;
    end
  end

  assign take      = insn_end && hit;
  assign vec_addr  = BASE + {{(15-IW){1'b0}}, win_idx, 1'b0};
  assign new_lvl   = win_lvl;
  assign ret_valid = iret && !ack && !empty;
  assign ret_lvl   = empty ? cur_lvl : stk[top_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth   <= '0;
      stk_err <= 1'b0;
      for (int i = 0; i < NSRC; i++) prio[i] <= 2'd3;
    end else begin
      if (wr_en && int'(wr_idx) < NSRC && wr_lvl != 2'd0)
        prio[wr_idx] <= wr_lvl;
      if (ack) begin
        if (full) stk_err <= 1'b1;
        else      depth   <= depth + 1'b1;
      end else if (iret) begin
        if (empty) stk_err <= 1'b1;
        else       depth   <= depth - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && ack && !full) stk[AW'(depth)] <= cur_lvl;
  end

  assert_take_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> insn_end);
  assert_level_rises_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !trap_req) |-> (new_lvl > cur_lvl));
  assert_trap_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && trap_req) |-> (take && vec_addr == 16'hFFFC && new_lvl == 2'd3));
  assert_push_grows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !full) |=> (depth == $past(depth) + 1'b1));
  assert_empty_return_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iret && !ack && empty) |=> stk_err);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  assert_simultaneous_no_return_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && iret) |-> !ret_valid);
endmodule

// File: tb/tb_nest_irq_ctrl.sv
module tb_nest_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic [12:0] irq_req;
  logic top_req, trap_req, wr_en, insn_end, ack, iret;
  logic [3:0] wr_idx;
  logic [1:0] wr_lvl, cur_lvl;
  logic take, ret_valid, stk_err;
  logic [15:0] vec_addr;
  logic [1:0] new_lvl, ret_lvl;
  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  nest_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .top_req(top_req), .trap_req(trap_req),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_lvl(wr_lvl), .cur_lvl(cur_lvl),
    .insn_end(insn_end), .ack(ack), .iret(iret), .take(take), .vec_addr(vec_addr),
    .new_lvl(new_lvl), .ret_valid(ret_valid), .ret_lvl(ret_lvl), .stk_err(stk_err));

  // {req, top, trap, cur, insn_end, exp_take, exp_vec, exp_lvl}
  localparam logic [36:0] VECS [16] = '{
    {13'h0000, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 16'h0000, 2'd0}, // R2 nothing pending
    {13'h0001, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFE0, 2'd1}, // R4 src0
    {13'h0001, 1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 16'h0000, 2'd0}, // R2 equal level masked
    {13'h0003, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFE2, 2'd2}, // R3 higher level
    {13'h0024, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFEA, 2'd3}, // R3 tie -> index 5
    {13'h0092, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 16'hFFEE, 2'd2}, // R3 tie -> index 7
    {13'h0012, 1'b0, 1'b0, 2'd2, 1'b1, 1'b0, 16'h0000, 2'd0}, // R2 masked
    {13'h1200, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFF8, 2'd1}, // R4 src12
    {13'h1800, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFF6, 2'd3}, // R5 src11
    {13'h0001, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0000, 2'd0}, // R1 no boundary
    {13'h0800, 1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 16'hFFFA, 2'd3}, // R6 top wins
    {13'h0000, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 16'h0000, 2'd0}, // R6 masked at 3
    {13'h0004, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0, 16'h0000, 2'd0}, // R6 all masked at 3
    {13'h0000, 1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 16'hFFFC, 2'd3}, // R7 trap at 3
    {13'h1FFF, 1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 16'hFFFC, 2'd3}, // R7 trap beats all
    {13'h0000, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0000, 2'd0}  // R1 trap waits
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_req = '0; top_req = 0; trap_req = 0; wr_en = 0; wr_idx = 0; wr_lvl = 0;
    cur_lvl = 0; insn_end = 0; ack = 0; iret = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(int idx, logic [1:0] lv);
    wr_en = 1; wr_idx = 4'(idx); wr_lvl = lv;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic push(logic [1:0] lv);
    cur_lvl = lv; ack = 1;
    @(negedge clk); ack = 0;
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 0; idle();
    do_reset();
    // R13 reset state
    insn_end = 1; #1;
    chk("R13 take idle", 32'(take), 0);
    chk("R13 stk_err", 32'(stk_err), 0);
    chk("R13 ret_lvl empty", 32'(ret_lvl), 32'(cur_lvl));
    // R8 reset level is 3
    irq_req = 13'h0001; cur_lvl = 2; #1;
    chk("R8 reset level take", 32'(take), 1);
    chk("R8 reset level 3", 32'(new_lvl), 3);
    @(negedge clk); idle();
    // program level = 1 + i%3
    for (int i = 0; i < 13; i++) wr(i, 2'(1 + i % 3));
    foreach (VECS[k]) begin
      {irq_req, top_req, trap_req, cur_lvl, insn_end} = VECS[k][36:19];
      #1;
      chk($sformatf("vec%0d R1-take", k), 32'(take), 32'(VECS[k][18]));
      if (VECS[k][18]) begin
        chk($sformatf("vec%0d R4 addr", k), 32'(vec_addr), 32'(VECS[k][17:2]));
        chk($sformatf("vec%0d R5 lvl", k), 32'(new_lvl), 32'(VECS[k][1:0]));
      end
      @(negedge clk);
    end
    idle();
    // R8 zero write ignored
    wr(0, 2'd2); wr(0, 2'd0);
    irq_req = 13'h0001; cur_lvl = 1; insn_end = 1; #1;
    chk("R8 zero write ignored take", 32'(take), 1);
    chk("R8 zero write ignored lvl", 32'(new_lvl), 2);
    @(negedge clk); idle();
    // R9 LIFO
    push(0); push(1); push(2);
    cur_lvl = 3; iret = 1; #1;
    chk("R9 ret_valid", 32'(ret_valid), 1);
    chk("R9 ret 2", 32'(ret_lvl), 2);
    @(negedge clk); #1;
    chk("R9 ret 1", 32'(ret_lvl), 1);
    @(negedge clk); #1;
    chk("R9 ret 0", 32'(ret_lvl), 0);
    @(negedge clk); #1;
    // R10 empty return
    chk("R10 ret_valid empty", 32'(ret_valid), 0);
    chk("R10 ret_lvl=cur", 32'(ret_lvl), 3);
    chk("R10 err before edge", 32'(stk_err), 0);
    @(negedge clk); iret = 0; #1;
    chk("R10 err set", 32'(stk_err), 1);
    @(negedge clk); @(negedge clk);
    chk("R10 err sticky", 32'(stk_err), 1);
    // R11 overflow
    do_reset();
    push(0); push(1); push(2); push(3);
    chk("R11 err clear at 4", 32'(stk_err), 0);
    push(1);
    chk("R11 overflow err", 32'(stk_err), 1);
    cur_lvl = 0; iret = 1; #1;
    chk("R11 top kept", 32'(ret_lvl), 3);
    @(negedge clk); #1;
    chk("R11 next 2", 32'(ret_lvl), 2);
    @(negedge clk); #1;
    chk("R11 next 1", 32'(ret_lvl), 1);
    @(negedge clk); #1;
    chk("R11 next 0", 32'(ret_lvl), 0);
    @(negedge clk); iret = 0;
    // R12 ack and iret together
    do_reset();
    push(1);
    cur_lvl = 2; ack = 1; iret = 1; #1;
    chk("R12 ret_valid low", 32'(ret_valid), 0);
    @(negedge clk); ack = 0; #1;
    chk("R12 pushed top", 32'(ret_lvl), 2);
    @(negedge clk); #1;
    chk("R12 older kept", 32'(ret_lvl), 1);
    chk("R12 no err", 32'(stk_err), 0);
    @(negedge clk); idle();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule